// File: doc/BRIEF.md
# Ordered Load Queue with Issue Gating

This block keeps, for one hardware thread, a circular queue of in-flight loads in program order. The dispatch stage writes a load's sequence number and its uncacheable flag into the slot the block names on `ins_slot`. Commit releases the loads older than a given sequence number from the head. A squash drops the loads younger than a given sequence number and pulls the tail back so that their slots are reused. Both commit and squash act on any number of entries in a single cycle.

The block also gates load issue. When the issue stage presents a slot and its at-commit indication, the block either forwards the request to memory or tells the issue stage to reschedule the load. Uncacheable loads go to memory only from the queue head and only when the load is at commit. If memory refuses a request, the block records a blocked-load report for the oldest refused load, which the pipeline acknowledges through a handled flag and then clears.

Top module: `lq_unit`

## Requirements
- R1: After a synchronous active-low reset, the queue is empty. `count` is 0. `full`, `blocked`, `handled` and `mem_req` are 0. `head_seq` and `blk_seq` are 0.
- R2: `full` is 1 exactly when `count` equals DEPTH-1, because one slot is kept as a sentinel. An insert presented while `full` is 1 is dropped and leaves `count` unchanged.
- R3: `ins_slot` always shows the current tail slot. An accepted insert writes that slot and raises `count` by one at the next clock edge. `head_seq` shows the oldest entry.
- R4: A commit with sequence number C releases, in one cycle, every entry whose sequence number is below C. The head advances past the released entries.
- R5: A squash with sequence number S removes, in one cycle, every entry whose sequence number is above S and moves the tail back by the same number. An insert in the same cycle as a squash is dropped.
- R6: In the cycle an issue request is presented, the verdict is as follows. A load marked uncacheable (`ins_uc`=1 at insert) that is not at the head slot, or whose `iss_at_commit` is 0, gives `resched`=1 and `mem_req`=0. Every other valid load gives `mem_req`=1 and `resched`=0.
- R7: When `mem_req`=1 and `mem_ready`=0 in the same cycle, the next cycle shows `blocked`=1 and `handled`=0, with `blk_seq` holding the refused load's sequence number.
- R8: While `blocked`=1, a refusal of a load whose sequence number is larger than `blk_seq` changes neither the record nor `handled`. A refusal of an older or equal load replaces the record.
- R9: `blk_clr` clears `blocked` and `hnd_set` sets `handled` at the next edge. A refusal that is recorded in the same cycle takes precedence over both.
- R10: `head_seq` reads 0 whenever the head slot is empty.
- R11: An issue request naming an empty slot gives neither `mem_req` nor `resched`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert a load at the tail |
| ins_seq | input | SEQ_W | Sequence number of the inserted load |
| ins_uc | input | 1 | Inserted load is uncacheable |
| ins_slot | output | IDX_W | Slot an insert would occupy (tail) |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Loads below this number are released |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Loads above this number are removed |
| iss_valid | input | 1 | Issue request for a queued load |
| iss_idx | input | IDX_W | Slot of the load asking to issue |
| iss_at_commit | input | 1 | Load is at commit |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_req | output | 1 | Load is sent to memory |
| resched | output | 1 | Load must be rescheduled |
| blk_clr | input | 1 | Clear the blocked-load report |
| hnd_set | input | 1 | Mark the blocked load as handled |
| blocked | output | 1 | A load was refused by memory |
| handled | output | 1 | Blocked load has been handled |
| blk_seq | output | SEQ_W | Sequence number of the recorded refused load |
| head_seq | output | SEQ_W | Sequence number at the head, 0 if empty |
| count | output | CNT_W | Number of queued loads |
| full | output | 1 | Queue holds DEPTH-1 loads |

## Verification
The hardest case to reach is a refusal from a younger load while an older refusal is still recorded. It needs a queue holding several loads, an earlier refusal that has not yet been cleared, and a second refused issue whose sequence number is larger. The directed stimulus builds this on purpose: it refuses one load, then refuses a younger one, then an older one, with handled and clear pulses in between. A random phase then mixes inserts, commits, squashes and refusals against a behavioural queue model. That phase also reaches wrap-around of the circular pointers, squashes that reach past a wrapped tail, and clear pulses that coincide with new refusals.

// File: rtl/lq_pkg.sv
// Shared types for the load queue.
// Assumes nothing beyond standard SystemVerilog.
package lq_pkg;
    // Outcome of an issue request for one cycle.
    typedef enum logic [1:0] {
        VERD_NONE    = 2'd0,
        VERD_SEND    = 2'd1,
        VERD_RESCHED = 2'd2
    } verdict_e;
endpackage

// File: rtl/lq_slots.sv
// Slot storage of the load queue: valid bit, sequence number and uncacheable
// flag per slot, plus per-slot release and removal masks for commit and squash.
// Assumes entries are held in program order, so the masks form a prefix
// (release) and a suffix (removal) of the occupied region.
module lq_slots #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SEQ_W-1:0] wr_seq,
    input  logic             wr_uc,
    input  logic             rel_en,
    input  logic [SEQ_W-1:0] rel_seq,
    input  logic             kill_en,
    input  logic [SEQ_W-1:0] kill_seq,
    output logic [DEPTH-1:0] vld,
    output logic [DEPTH-1:0] ucf,
    output logic [SEQ_W-1:0] seqs [DEPTH],
    output logic [DEPTH-1:0] rel_mask,
    output logic [DEPTH-1:0] kill_mask
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_wr;

        // Address decode of the insert for this slot.
        always_comb hit_wr = wr_en && (int'(wr_idx) == g);

        // Commit and squash selection for this slot.
        always_comb begin
            rel_mask[g]  = vld[g] && rel_en && (seqs[g] < rel_seq);
            kill_mask[g] = vld[g] && kill_en && (seqs[g] > kill_seq);
        end

        // Slot state: written on insert, freed on release or removal.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[g]  <= 1'b0;
                ucf[g]  <= 1'b0;
                seqs[g] <= '0;
            end else if (hit_wr) begin
                vld[g]  <= 1'b1;
                ucf[g]  <= wr_uc;
                seqs[g] <= wr_seq;
            end else if (rel_mask[g] || kill_mask[g]) begin
                vld[g]  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lq_ptrs.sv
// Head, tail and occupancy of the circular load queue.
// Assumes the caller never pushes while full or during a squash, and that
// release and removal counts never exceed the occupancy.
module lq_ptrs #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [CNT_W-1:0] rel_n,
    input  logic [CNT_W-1:0] kill_n,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    localparam int LIMIT = DEPTH - 1;

    // Forward move of a slot index, modulo the queue depth.
    function automatic logic [IDX_W-1:0] step_fwd(input logic [IDX_W-1:0] p, input int n);
        int t;
        t = (int'(p) + n) % DEPTH;
        return IDX_W'(t);
    endfunction

    // Backward move of a slot index, modulo the queue depth.
    function automatic logic [IDX_W-1:0] step_back(input logic [IDX_W-1:0] p, input int n);
        int t;
        t = (int'(p) + DEPTH - n) % DEPTH;
        return IDX_W'(t);
    endfunction

    // One slot is kept as sentinel, so capacity is DEPTH-1.
    always_comb full = (int'(count) >= LIMIT);

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            head  <= step_fwd(head, int'(rel_n));
            tail  <= push ? step_fwd(tail, 1) : step_back(tail, int'(kill_n));
            count <= count + CNT_W'(push) - rel_n - kill_n;
        end
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= LIMIT);

    a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rel_n == '0 && kill_n == '0) |=> (count == $past(count) + 1'b1));

    a_r5_kill_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && rel_n == '0 && kill_n != '0) |=> (count == $past(count) - $past(kill_n)));
endmodule

// File: rtl/lq_issue.sv
// Issue gating and blocked-load report.
// Decides per cycle whether the presented load goes to memory or must be
// rescheduled. Records the oldest load that memory refused.
// Assumes slot fields are already selected by the caller for the requested index.
module lq_issue
    import lq_pkg::*;
#(
    parameter int SEQ_W = 16,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             req_at_commit,
    input  logic             slot_valid,
    input  logic             slot_uc,
    input  logic [SEQ_W-1:0] slot_seq,
    input  logic [IDX_W-1:0] head,
    input  logic             mem_ready,
    input  logic             blk_clr,
    input  logic             hnd_set,
    output logic             mem_req,
    output logic             resched,
    output logic             blocked,
    output logic             handled,
    output logic [SEQ_W-1:0] blk_seq
);
    verdict_e verdict;
    logic     refused;
    logic     keep_old;
    logic     take;

    // Verdict: uncacheable loads only leave from the head when at commit.
    always_comb begin
        if (!req_valid || !slot_valid)
            verdict = VERD_NONE;
        else if (slot_uc && (req_idx != head || !req_at_commit))
            verdict = VERD_RESCHED;
        else
            verdict = VERD_SEND;
    end

    always_comb begin
        mem_req = (verdict == VERD_SEND);
        resched = (verdict == VERD_RESCHED);
    end

    // A refusal is recorded unless an older refused load is already held.
    always_comb begin
        refused  = mem_req && !mem_ready;
        keep_old = blocked && (blk_seq < slot_seq);
        take     = refused && !keep_old;
    end

    // Blocked-load report registers; a new record beats clear and handled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blocked <= 1'b0;
            handled <= 1'b0;
            blk_seq <= '0;
        end else if (take) begin
            blocked <= 1'b1;
            handled <= 1'b0;
            blk_seq <= slot_seq;
        end else begin
            if (blk_clr) blocked <= 1'b0;
            if (hnd_set) handled <= 1'b1;
        end
    end

    a_r6_uc_from_head: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && slot_uc) |-> (req_idx == head && req_at_commit));

    a_r7_refusal_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready && !(blocked && blk_seq < slot_seq))
            |=> (blocked && !handled && blk_seq == $past(slot_seq)));

    a_r8_older_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && mem_req && !mem_ready && blk_seq < slot_seq && !blk_clr)
            |=> (blocked && $stable(blk_seq)));

    a_r11_no_verdict_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !slot_valid) |-> (!mem_req && !resched));
endmodule

// File: rtl/lq_unit.sv
// Per-thread ordered load queue.
// Inserts at the tail, releases committed loads from the head, and drops
// squashed loads from the tail, all in one cycle. Gates issue of each load
// and reports the oldest load refused by memory.
// Assumes sequence numbers increase along the queue and do not wrap.
module lq_unit #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [SEQ_W-1:0] ins_seq,
    input  logic             ins_uc,
    output logic [IDX_W-1:0] ins_slot,
    input  logic             cmt_valid,
    input  logic [SEQ_W-1:0] cmt_seq,
    input  logic             sq_valid,
    input  logic [SEQ_W-1:0] sq_seq,
    input  logic             iss_valid,
    input  logic [IDX_W-1:0] iss_idx,
    input  logic             iss_at_commit,
    input  logic             mem_ready,
    output logic             mem_req,
    output logic             resched,
    input  logic             blk_clr,
    input  logic             hnd_set,
    output logic             blocked,
    output logic             handled,
    output logic [SEQ_W-1:0] blk_seq,
    output logic [SEQ_W-1:0] head_seq,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    logic [DEPTH-1:0] vld, ucf, rel_mask, kill_mask;
    logic [SEQ_W-1:0] seqs [DEPTH];
    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] rel_n, kill_n;
    logic             push;
    logic             sel_ok, sel_valid, sel_uc;
    logic [SEQ_W-1:0] sel_seq;

    // Insert accepted only with room and no squash in flight.
    always_comb push = ins_valid && !full && !sq_valid;

    // Number of entries released and removed this cycle.
    always_comb begin
        rel_n  = CNT_W'($countones(rel_mask));
        kill_n = CNT_W'($countones(kill_mask));
    end

    // Fields of the slot named by the issue request.
    always_comb begin
        sel_ok    = int'(iss_idx) < DEPTH;
        sel_valid = sel_ok ? vld[iss_idx]  : 1'b0;
        sel_uc    = sel_ok ? ucf[iss_idx]  : 1'b0;
        sel_seq   = sel_ok ? seqs[iss_idx] : '0;
    end

    // Head sequence number, zero for an empty head slot.
    always_comb head_seq = vld[head] ? seqs[head] : '0;

    always_comb ins_slot = tail;

    lq_slots #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (push),
        .wr_idx    (tail),
        .wr_seq    (ins_seq),
        .wr_uc     (ins_uc),
        .rel_en    (cmt_valid),
        .rel_seq   (cmt_seq),
        .kill_en   (sq_valid),
        .kill_seq  (sq_seq),
        .vld       (vld),
        .ucf       (ucf),
        .seqs      (seqs),
        .rel_mask  (rel_mask),
        .kill_mask (kill_mask)
    );

    lq_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (push),
        .rel_n  (rel_n),
        .kill_n (kill_n),
        .head   (head),
        .tail   (tail),
        .count  (count),
        .full   (full)
    );

    lq_issue #(.SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (iss_valid),
        .req_idx       (iss_idx),
        .req_at_commit (iss_at_commit),
        .slot_valid    (sel_valid),
        .slot_uc       (sel_uc),
        .slot_seq      (sel_seq),
        .head          (head),
        .mem_ready     (mem_ready),
        .blk_clr       (blk_clr),
        .hnd_set       (hnd_set),
        .mem_req       (mem_req),
        .resched       (resched),
        .blocked       (blocked),
        .handled       (handled),
        .blk_seq       (blk_seq)
    );

    a_r10_empty_head_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (head_seq == '0));

    a_r4_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !sq_valid && !push) |=> (count == $past(count) - $past(rel_n)));
endmodule

// File: tb/tb_lq_unit.sv
module tb_lq_unit;
    localparam int CLK_NS = 10;
    localparam int D      = 8;
    localparam int SW     = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ins_valid, ins_uc, cmt_valid, sq_valid, iss_valid, iss_at_commit;
    logic          mem_ready, blk_clr, hnd_set;
    logic [SW-1:0] ins_seq, cmt_seq, sq_seq;
    logic [2:0]    iss_idx;
    logic [2:0]    ins_slot;
    logic          mem_req, resched, blocked, handled, full;
    logic [SW-1:0] blk_seq, head_seq;
    logic [3:0]    count;

    int vectors = 0;
    int miss    = 0;
    bit done    = 0;

    // Reference model state.
    int q_seq[$];
    bit q_uc[$];
    int q_slot[$];
    int m_head, m_tail, m_bseq;
    bit m_blk, m_hnd;
    int next_seq;

    always #(CLK_NS/2) clk = ~clk;

    lq_unit #(.DEPTH(D), .SEQ_W(SW)) dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_uc(ins_uc), .ins_slot(ins_slot),
        .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .iss_valid(iss_valid), .iss_idx(iss_idx), .iss_at_commit(iss_at_commit),
        .mem_ready(mem_ready), .mem_req(mem_req), .resched(resched),
        .blk_clr(blk_clr), .hnd_set(hnd_set),
        .blocked(blocked), .handled(handled), .blk_seq(blk_seq),
        .head_seq(head_seq), .count(count), .full(full)
    );

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int pos_of_slot(int idx);
        foreach (q_slot[i]) if (q_slot[i] == idx) return i;
        return -1;
    endfunction

    function automatic int slot_of_seq(int s);
        foreach (q_seq[i]) if (q_seq[i] == s) return q_slot[i];
        return 0;
    endfunction

    task automatic idle();
        ins_valid = 0; ins_uc = 0; ins_seq = '0;
        cmt_valid = 0; cmt_seq = '0; sq_valid = 0; sq_seq = '0;
        iss_valid = 0; iss_idx = '0; iss_at_commit = 0; mem_ready = 1;
        blk_clr = 0; hnd_set = 0;
    endtask

    // One clock: check the same-cycle outputs, advance the model, check registered outputs.
    task automatic cycle();
        int  pos;
        bit  e_req, e_rs;
        int  pre_n;
        #1;
        pos   = pos_of_slot(int'(iss_idx));
        e_req = 0; e_rs = 0;
        if (iss_valid && pos >= 0) begin
            if (q_uc[pos] && (int'(iss_idx) != m_head || !iss_at_commit)) e_rs = 1;
            else e_req = 1;
        end
        chk("R6", "mem_req", int'(mem_req), int'(e_req));
        chk("R6", "resched", int'(resched), int'(e_rs));
        chk("R3", "ins_slot", int'(ins_slot), m_tail);
        @(posedge clk);
        pre_n = q_seq.size();
        if (e_req && !mem_ready && !(m_blk && m_bseq < q_seq[pos])) begin
            m_blk = 1; m_hnd = 0; m_bseq = q_seq[pos];
        end else begin
            if (blk_clr) m_blk = 0;
            if (hnd_set) m_hnd = 1;
        end
        if (cmt_valid)
            while (q_seq.size() > 0 && q_seq[0] < int'(cmt_seq)) begin
                void'(q_seq.pop_front()); void'(q_uc.pop_front()); void'(q_slot.pop_front());
                m_head = (m_head + 1) % D;
            end
        if (sq_valid)
            while (q_seq.size() > 0 && q_seq[$] > int'(sq_seq)) begin
                void'(q_seq.pop_back()); void'(q_uc.pop_back()); void'(q_slot.pop_back());
                m_tail = (m_tail + D - 1) % D;
            end
        if (ins_valid && !sq_valid && pre_n < D - 1) begin
            q_seq.push_back(int'(ins_seq)); q_uc.push_back(ins_uc); q_slot.push_back(m_tail);
            m_tail = (m_tail + 1) % D;
        end
        @(negedge clk);
        chk("R3", "count", int'(count), q_seq.size());
        chk("R2", "full", int'(full), int'(q_seq.size() == D - 1));
        chk("R10", "head_seq", int'(head_seq), (q_seq.size() > 0) ? q_seq[0] : 0);
        chk("R7", "blocked", int'(blocked), int'(m_blk));
        chk("R9", "handled", int'(handled), int'(m_hnd));
        chk("R8", "blk_seq", int'(blk_seq), m_bseq);
        idle();
    endtask

    task automatic do_ins(int s, bit uc);
        ins_valid = 1; ins_seq = SW'(s); ins_uc = uc; cycle();
    endtask

    task automatic do_iss(int s, bit atc, bit rdy);
        iss_valid = 1; iss_idx = 3'(slot_of_seq(s)); iss_at_commit = atc; mem_ready = rdy;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            miss++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 0;
        m_head = 0; m_tail = 0; m_blk = 0; m_hnd = 0; m_bseq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "count", int'(count), 0);
        chk("R1", "full", int'(full), 0);
        chk("R1", "blocked", int'(blocked), 0);
        chk("R1", "handled", int'(handled), 0);
        chk("R1", "blk_seq", int'(blk_seq), 0);
        chk("R1", "head_seq", int'(head_seq), 0);
        chk("R1", "mem_req", int'(mem_req), 0);

        // R3: three inserts, the last one uncacheable
        do_ins(10, 0); do_ins(11, 0); do_ins(12, 1);
        chk("R3", "head_seq after inserts", int'(head_seq), 10);
        // R6: cacheable issue goes out; uncacheable off-head is rescheduled
        do_iss(11, 0, 1); #1; chk("R6", "cacheable sends", int'(mem_req), 1); cycle();
        do_iss(12, 1, 1); #1; chk("R6", "uc off head", int'(resched), 1); cycle();
        // R4: commit releases 10 and 11 together
        cmt_valid = 1; cmt_seq = 12; cycle();
        chk("R4", "head after commit", int'(head_seq), 12);
        chk("R4", "count after commit", int'(count), 1);
        do_iss(12, 0, 1); #1; chk("R6", "uc head not at commit", int'(resched), 1); cycle();
        do_iss(12, 1, 1); #1; chk("R6", "uc head at commit", int'(mem_req), 1); cycle();
        // R2: fill to DEPTH-1 then try one more
        for (int s = 13; s <= 18; s++) do_ins(s, 0);
        chk("R2", "full at capacity", int'(full), 1);
        do_ins(19, 0);
        chk("R2", "insert when full dropped", int'(count), D - 1);
        // R5: squash above 15, with a simultaneous insert that must be dropped
        sq_valid = 1; sq_seq = 15; ins_valid = 1; ins_seq = 30; cycle();
        chk("R5", "count after squash", int'(count), 4);
        do_ins(20, 0);
        chk("R5", "reuse after squash", int'(count), 5);
        // R7: refusal records the load
        do_iss(14, 0, 0); cycle();
        chk("R7", "blk_seq", int'(blk_seq), 14);
        // R8: younger refusal keeps the record
        do_iss(15, 0, 0); cycle();
        chk("R8", "younger kept", int'(blk_seq), 14);
        // R9: handled set
        hnd_set = 1; cycle();
        chk("R9", "handled set", int'(handled), 1);
        // R8: older refusal replaces the record and clears handled
        do_iss(13, 0, 0); cycle();
        chk("R8", "older replaces", int'(blk_seq), 13);
        chk("R7", "handled cleared", int'(handled), 0);
        // R9: clear, then clear together with a new refusal
        blk_clr = 1; cycle();
        chk("R9", "cleared", int'(blocked), 0);
        do_iss(20, 0, 0); blk_clr = 1; cycle();
        chk("R9", "refusal beats clear", int'(blocked), 1);
        // R11: issue on an empty slot
        iss_valid = 1; iss_idx = 3'(m_tail); #1;
        chk("R11", "empty slot mem_req", int'(mem_req), 0);
        chk("R11", "empty slot resched", int'(resched), 0);
        cycle();
        // R10: commit everything
        cmt_valid = 1; cmt_seq = 100; cycle();
        chk("R10", "empty head zero", int'(head_seq), 0);

        // Random phase against the model.
        next_seq = 200;
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 1) == 1) begin
                ins_valid = 1; ins_seq = SW'(next_seq); ins_uc = ($urandom_range(0, 3) == 0);
                next_seq += $urandom_range(1, 3);
            end
            if (r < 15) begin
                cmt_valid = 1;
                cmt_seq = (q_seq.size() > 0) ? SW'(q_seq[$urandom_range(0, q_seq.size() - 1)] + 1) : SW'(next_seq);
            end else if (r < 25) begin
                sq_valid = 1;
                sq_seq = (q_seq.size() > 0) ? SW'(q_seq[$urandom_range(0, q_seq.size() - 1)] - 1) : SW'(next_seq);
            end
            if ($urandom_range(0, 9) < 6) begin
                iss_valid = 1; iss_idx = 3'($urandom_range(0, D - 1));
                iss_at_commit = $urandom_range(0, 1) == 1;
                mem_ready = $urandom_range(0, 9) < 7;
            end
            blk_clr = $urandom_range(0, 9) == 0;
            hnd_set = $urandom_range(0, 9) == 0;
            cycle();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end
endmodule